// File: doc/BRIEF.md
# Reader Front-End Serial Command Controller

This block is the slave side of a three-wire link that a host microcontroller uses to configure and run an RFID reader front end. The wires are a serial clock, a serial data input and an open-drain data output. Both inputs are brought into the system clock domain through synchroniser chains, and every edge is detected there.

A frame opens when the data line rises while the serial clock is high. Opcode bits are then sampled MSB first on each rising serial clock edge. Two short three-bit opcodes switch the block into a tag-read streaming mode or a tag-write mode as soon as their third bit arrives. All other opcodes are eight bits long. They set the sampling time, set the write pulse count, write one of four 4-bit configuration pages, or request an 8-bit read-back.

Read-back bytes go out MSB first, one bit on each rising serial clock edge. The stored pulse count, the sampling time, all configuration bits and the mode flags are exported to the rest of the reader.

Top module: `rdr_cmd_if`

## Requirements
- R1: A rising edge of the data line while the serial clock is high aborts whatever the block is doing, releases the data output and starts a new opcode frame. This applies in every state, including the middle of an opcode or a response.
- R2: Opcode bits are taken from the data line on rising serial clock edges, with the first bit as the most significant.
- R3: An opcode whose first three bits are 1,1,1 enters tag-read mode on the third bit. In that mode the data output follows the digitised demodulator input. First bits 1,1,0 enter tag-write mode on the third bit, keeping the stored pulse count.
- R4: Opcode 10DDDDDD stores the 6-bit sampling time D. Opcode 00000010 returns 00 followed by the stored sampling time.
- R5: Tag-read mode and tag-write mode each end on the next rising serial clock edge. The two modes and the response phase are never active together.
- R6: Opcode 01PPDDDD writes D into configuration page PP. Opcode 000001PP returns that page's 4 bits in the low nibble. The high nibble is the pulse count for pages 0 and 1, and 0,0,amplitude-compare,antenna-fail for pages 2 and 3. The configuration output holds page k at bits 4k+3..4k.
- R7: After reset all configuration pages, the pulse count and the sampling time are zero, no mode is active and the data output is high.
- R8: Opcode 00001000 returns 00 followed by the 6-bit phase input, captured when the opcode completes.
- R9: Opcode 0001NNNN stores N as the pulse count and enters tag-write mode.
- R10: A response is driven MSB first, one bit on each of the eight rising serial clock edges that follow the opcode. The ninth rising edge releases the data output high. Outside a response and outside tag-read mode the data output is high.
- R11: An eight-bit opcode that matches none of the above changes no stored value, enters no mode and leaves the data output released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| din_i | input | 1 | Serial data from the host (asynchronous) |
| dout_o | output | 1 | Serial data to the host; 1 means released |
| demod_bit_i | input | 1 | Digitised demodulator output, streamed in tag-read mode |
| phase_i | input | 6 | Measured antenna phase |
| amp_cmp_i | input | 1 | Amplitude comparison status |
| ant_fail_i | input | 1 | Antenna failure status |
| read_mode_o | output | 1 | Tag-read mode active |
| write_mode_o | output | 1 | Tag-write mode active |
| pulse_n_o | output | 4 | Stored write pulse count |
| samp_time_o | output | 6 | Stored sampling time |
| cfg_o | output | 16 | Configuration pages 3..0 concatenated |

## Verification
The assertions take for granted that the host holds each level on the serial lines for several system clocks, so that no pulse is lost in the synchronisers. They also assume the data line changes only while the serial clock is low, except when the host means to issue a start. Given that, one rising clock edge yields exactly one shift, and a start is never mistaken for data. The stimulus changes the data line with the clock low and holds every phase for four system clocks. The status and phase inputs change only between frames.

// File: rtl/rdr_cmd_pkg.sv
package rdr_cmd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_RESP,
      ST_READ,
      ST_WRITE
   } frame_st_e;

   typedef enum logic [3:0] {
      ACT_NONE,
      ACT_READ,
      ACT_WRITE,
      ACT_WRITE_N,
      ACT_SET_SAMP,
      ACT_SET_PAGE,
      ACT_GET_PHASE,
      ACT_GET_SAMP,
      ACT_GET_PAGE
   } cmd_act_e;

   // full-length opcode classification
   function automatic cmd_act_e decode_full(input logic [7:0] op);
      cmd_act_e a;
      a = ACT_NONE;
      if (op[7:4] == 4'b0001)      a = ACT_WRITE_N;
      else if (op[7:6] == 2'b10)   a = ACT_SET_SAMP;
      else if (op[7:6] == 2'b01)   a = ACT_SET_PAGE;
      else if (op == 8'b0000_1000) a = ACT_GET_PHASE;
      else if (op == 8'b0000_0010) a = ACT_GET_SAMP;
      else if (op[7:2] == 6'b000001) a = ACT_GET_PAGE;
      return a;
   endfunction

endpackage

// File: rtl/rdr_sync.sv
module rdr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rdr_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain_q[i] <= RST_VAL;
            else if (i == 0)
               chain_q[i] <= d_i;
            else
               chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rdr_frame.sv
module rdr_frame
   import rdr_cmd_pkg::*;
#(
   parameter int CMD_W     = 8,
   parameter int SHORT_LEN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_lvl_i,
   input  logic             sclk_rise_i,
   input  logic             din_lvl_i,
   input  logic             din_rise_i,
   input  logic [CMD_W-1:0] resp_i,
   output logic             act_vld_o,
   output cmd_act_e         act_o,
   output logic [CMD_W-1:0] byte_o,
   output logic             read_mode_o,
   output logic             write_mode_o,
   output logic             resp_active_o,
   output logic             dout_q_o
);
   localparam int CNT_W = $clog2(CMD_W + 1);

   frame_st_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CMD_W-1:0] sh_q;
   logic             dout_q;

   logic             start, shift_ev, short_hit, full_hit;
   logic [CMD_W-1:0] byte_nx;

   always_comb begin
      start     = din_rise_i & sclk_lvl_i;
      shift_ev  = sclk_rise_i & ~start;
      byte_nx   = {sh_q[CMD_W-2:0], din_lvl_i};
      short_hit = (cnt_q == CNT_W'(SHORT_LEN-1)) && (byte_nx[2:1] == 2'b11);
      full_hit  = (cnt_q == CNT_W'(CMD_W-1));
      act_vld_o = (state_q == ST_CMD) && shift_ev && (short_hit || full_hit);
      if (short_hit) act_o = byte_nx[0] ? ACT_READ : ACT_WRITE;
      else           act_o = decode_full(byte_nx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         sh_q    <= '0;
         dout_q  <= 1'b1;
      end else if (start) begin
         state_q <= ST_CMD;
         cnt_q   <= '0;
         sh_q    <= '0;
         dout_q  <= 1'b1;
      end else if (shift_ev) begin
         case (state_q)
            ST_CMD: begin
               if (act_vld_o) begin
                  case (act_o)
                     ACT_READ:                  state_q <= ST_READ;
                     ACT_WRITE, ACT_WRITE_N:    state_q <= ST_WRITE;
                     ACT_GET_PHASE, ACT_GET_SAMP, ACT_GET_PAGE: begin
                        state_q <= ST_RESP;
                        sh_q    <= resp_i;
                        cnt_q   <= '0;
                     end
                     default:                   state_q <= ST_IDLE;
                  endcase
               end else begin
                  sh_q  <= byte_nx;
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_RESP: begin
               if (cnt_q == CNT_W'(CMD_W)) begin
                  state_q <= ST_IDLE;
                  dout_q  <= 1'b1;
               end else begin
                  dout_q <= sh_q[CMD_W-1];
                  sh_q   <= {sh_q[CMD_W-2:0], 1'b0};
                  cnt_q  <= cnt_q + 1'b1;
               end
            end
            ST_READ, ST_WRITE: state_q <= ST_IDLE;
            default: ;
         endcase
      end
   end

   assign byte_o        = byte_nx;
   assign read_mode_o   = (state_q == ST_READ);
   assign write_mode_o  = (state_q == ST_WRITE);
   assign resp_active_o = (state_q == ST_RESP);
   assign dout_q_o      = dout_q;

   // R5
   mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({read_mode_o, write_mode_o, resp_active_o}));
   // R5
   read_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (read_mode_o && sclk_rise_i && !din_rise_i) |=> !read_mode_o);
   // R3
   write_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(write_mode_o) |-> $past(sclk_rise_i));
endmodule

// File: rtl/rdr_regs.sv
module rdr_regs
   import rdr_cmd_pkg::*;
#(
   parameter int PAGES   = 4,
   parameter int PAGE_W  = 4,
   parameter int N_W     = 4,
   parameter int SAMP_W  = 6,
   parameter int PHASE_W = 6,
   parameter int RESP_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    act_vld_i,
   input  cmd_act_e                act_i,
   input  logic [5:0]              byte_i,
   input  logic [PHASE_W-1:0]      phase_i,
   input  logic                    amp_cmp_i,
   input  logic                    ant_fail_i,
   output logic [RESP_W-1:0]       resp_o,
   output logic [N_W-1:0]          pulse_n_o,
   output logic [SAMP_W-1:0]       samp_time_o,
   output logic [PAGES*PAGE_W-1:0] cfg_o
);
   localparam int SEL_W = $clog2(PAGES);

   logic [N_W-1:0]    n_q;
   logic [SAMP_W-1:0] samp_q;
   logic [PAGE_W-1:0] page_q [PAGES];
   logic [SEL_W-1:0]  wr_sel, rd_sel;
   logic [N_W-1:0]    hi_nib;

   assign wr_sel = byte_i[PAGE_W +: SEL_W];
   assign rd_sel = byte_i[SEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q    <= '0;
         samp_q <= '0;
      end else if (act_vld_i) begin
         if (act_i == ACT_WRITE_N)  n_q    <= byte_i[N_W-1:0];
         if (act_i == ACT_SET_SAMP) samp_q <= byte_i[SAMP_W-1:0];
      end
   end

   generate
      for (genvar p = 0; p < PAGES; p++) begin : g_page
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               page_q[p] <= '0;
            else if (act_vld_i && act_i == ACT_SET_PAGE && wr_sel == SEL_W'(p))
               page_q[p] <= byte_i[PAGE_W-1:0];
         end
         assign cfg_o[p*PAGE_W +: PAGE_W] = page_q[p];
      end
   endgenerate

   always_comb begin
      hi_nib = (rd_sel < SEL_W'(2)) ? n_q : N_W'({amp_cmp_i, ant_fail_i});
      case (act_i)
         ACT_GET_PHASE: resp_o = RESP_W'(phase_i);
         ACT_GET_SAMP:  resp_o = RESP_W'(samp_q);
         ACT_GET_PAGE:  resp_o = {hi_nib, page_q[rd_sel]};
         default:       resp_o = '0;
      endcase
   end

   assign pulse_n_o   = n_q;
   assign samp_time_o = samp_q;

   // R4
   samp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_vld_i && act_i == ACT_SET_SAMP) |=> $stable(samp_time_o));
   // R6
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_vld_i && act_i == ACT_SET_PAGE) |=> $stable(cfg_o));
   // R9
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_vld_i && act_i == ACT_WRITE_N) |=> $stable(pulse_n_o));
endmodule

// File: rtl/rdr_cmd_if.sv
module rdr_cmd_if
   import rdr_cmd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PAGES       = 4,
   parameter int PAGE_W      = 4,
   parameter int N_W         = 4,
   parameter int SAMP_W      = 6,
   parameter int PHASE_W     = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sclk_i,
   input  logic                    din_i,
   output logic                    dout_o,
   input  logic                    demod_bit_i,
   input  logic [PHASE_W-1:0]      phase_i,
   input  logic                    amp_cmp_i,
   input  logic                    ant_fail_i,
   output logic                    read_mode_o,
   output logic                    write_mode_o,
   output logic [N_W-1:0]          pulse_n_o,
   output logic [SAMP_W-1:0]       samp_time_o,
   output logic [PAGES*PAGE_W-1:0] cfg_o
);
   localparam int CMD_W = 8;

   generate
      if (PAGES != 4 || PAGE_W != 4 || N_W != 4)
         begin : g_bad_page $error("opcode format fixes four 4-bit pages and a 4-bit count"); end
      if (SAMP_W != 6 || PHASE_W != 6)
         begin : g_bad_val $error("opcode format fixes 6-bit sampling time and phase"); end
   endgenerate

   logic sclk_lvl, sclk_rise, din_lvl, din_rise;
   logic act_vld, resp_active, dout_q;
   cmd_act_e act;
   logic [CMD_W-1:0] cmd_byte, resp_word;

   rdr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d_i(sclk_i), .lvl_o(sclk_lvl), .rise_o(sclk_rise));

   rdr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d_i(din_i), .lvl_o(din_lvl), .rise_o(din_rise));

   rdr_frame #(.CMD_W(CMD_W)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .sclk_lvl_i(sclk_lvl), .sclk_rise_i(sclk_rise),
      .din_lvl_i(din_lvl), .din_rise_i(din_rise),
      .resp_i(resp_word), .act_vld_o(act_vld), .act_o(act), .byte_o(cmd_byte),
      .read_mode_o(read_mode_o), .write_mode_o(write_mode_o),
      .resp_active_o(resp_active), .dout_q_o(dout_q));

   rdr_regs #(.PAGES(PAGES), .PAGE_W(PAGE_W), .N_W(N_W), .SAMP_W(SAMP_W),
              .PHASE_W(PHASE_W), .RESP_W(CMD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .act_vld_i(act_vld), .act_i(act),
      .byte_i(cmd_byte[5:0]), .phase_i(phase_i),
      .amp_cmp_i(amp_cmp_i), .ant_fail_i(ant_fail_i), .resp_o(resp_word),
      .pulse_n_o(pulse_n_o), .samp_time_o(samp_time_o), .cfg_o(cfg_o));

   assign dout_o = read_mode_o ? demod_bit_i : dout_q;

   // R10
   dout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!read_mode_o && !resp_active) |-> dout_o);
   // R1
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (din_rise && sclk_lvl) |=> (dout_o && !read_mode_o && !write_mode_o));
endmodule

// File: tb/rdr_cmd_if_test.sv
module rdr_cmd_if_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, din = 1'b0, demod = 1'b0, amp = 1'b0, ant = 1'b0;
   logic [5:0] phase = '0;
   logic       dout, rmode, wmode;
   logic [3:0] pn;
   logic [5:0] samp;
   logic [15:0] cfg;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [3:0] m_n = '0;
   logic [5:0] m_samp = '0;
   logic [3:0] m_page [4] = '{default: '0};

   always #4 clk = ~clk;

   rdr_cmd_if uut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .din_i(din), .dout_o(dout),
      .demod_bit_i(demod), .phase_i(phase), .amp_cmp_i(amp), .ant_fail_i(ant),
      .read_mode_o(rmode), .write_mode_o(wmode), .pulse_n_o(pn),
      .samp_time_o(samp), .cfg_o(cfg));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hold();
      repeat (4) @(negedge clk);
   endtask

   task automatic start_frame();
      din = 1'b0; hold();
      sclk = 1'b1; hold();
      din = 1'b1; hold();
      sclk = 1'b0; hold();
   endtask

   task automatic send_bit(input logic b);
      din = b; hold();
      sclk = 1'b1; hold();
      sclk = 1'b0; hold();
   endtask

   task automatic send_byte(input logic [7:0] v);
      start_frame();
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic get_resp(output logic [7:0] r, output logic rel);
      for (int i = 7; i >= 0; i--) begin
         sclk = 1'b1; hold();
         r[i] = dout;
         sclk = 1'b0; hold();
      end
      sclk = 1'b1; hold();
      rel = dout;
      sclk = 1'b0; hold();
   endtask

   function automatic logic [15:0] m_cfg();
      return {m_page[3], m_page[2], m_page[1], m_page[0]};
   endfunction

   initial begin
      while (!done) begin
         @(negedge clk);
         if ($time > 64'd1_520_000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [7:0] r;
      logic       rel;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      hold();
      // R7 reset state
      chk("R7 cfg", cfg, 0);
      chk("R7 count", pn, 0);
      chk("R7 samp", samp, 0);
      chk("R7 modes", {rmode, wmode}, 0);
      chk("R7 dout", dout, 1);

      // R2 R4 sampling time sweep with readback (R10 release)
      for (int v = 0; v < 64; v++) begin
         send_byte(8'h80 | 8'(v));
         m_samp = 6'(v);
         chk("R2 R4 samp_out", samp, m_samp);
         send_byte(8'h02);
         get_resp(r, rel);
         chk("R4 R10 samp_resp", r, {2'b00, m_samp});
         chk("R10 release", rel, 1);
      end

      // R6 page sweep with readback and status variation
      for (int p = 0; p < 4; p++) begin
         for (int d = 0; d < 16; d++) begin
            amp = d[0]; ant = d[1];
            send_byte(8'h40 | 8'(p << 4) | 8'(d));
            m_page[p] = 4'(d);
            chk("R6 cfg_out", cfg, m_cfg());
            send_byte(8'h04 | 8'(p));
            get_resp(r, rel);
            chk("R6 page_resp", r,
                {(p < 2) ? m_n : {2'b00, amp, ant}, m_page[p]});
         end
      end

      // R9 R5 pulse count sweep
      for (int n = 0; n < 16; n++) begin
         send_byte(8'h10 | 8'(n));
         m_n = 4'(n);
         chk("R9 write_mode", wmode, 1);
         chk("R9 count", pn, m_n);
         sclk = 1'b1; hold();
         chk("R5 write_exit", wmode, 0);
         sclk = 1'b0; hold();
         send_byte(8'h05);
         get_resp(r, rel);
         chk("R6 R9 page1_hi", r, {m_n, m_page[1]});
      end

      // R8 phase sweep
      for (int v = 0; v < 64; v += 3) begin
         phase = 6'(v);
         send_byte(8'h08);
         phase = ~6'(v);
         get_resp(r, rel);
         chk("R8 phase_resp", r, {2'b00, 6'(v)});
      end

      // R3 short write: mode after third bit, count kept
      start_frame();
      send_bit(1); send_bit(1); send_bit(0);
      chk("R3 short_write", {rmode, wmode}, 2'b01);
      chk("R3 count_kept", pn, m_n);
      sclk = 1'b1; hold();
      chk("R5 short_write_exit", wmode, 0);
      sclk = 1'b0; hold();

      // R3 short read: streaming of demodulator bit
      start_frame();
      send_bit(1); send_bit(1); send_bit(1);
      chk("R3 short_read", {rmode, wmode}, 2'b10);
      demod = 1'b0; @(negedge clk);
      chk("R3 stream0", dout, 0);
      demod = 1'b1; @(negedge clk);
      chk("R3 stream1", dout, 1);
      demod = 1'b0; @(negedge clk);
      sclk = 1'b1; hold();
      chk("R5 read_exit", rmode, 0);
      chk("R10 dout_after_read", dout, 1);
      sclk = 1'b0; hold();

      // R11 unrecognised opcodes
      foreach (r[i]) ;
      for (int k = 0; k < 5; k++) begin
         logic [7:0] op;
         case (k)
            0: op = 8'h00;
            1: op = 8'h03;
            2: op = 8'h0C;
            3: op = 8'h20;
            default: op = 8'h09;
         endcase
         send_byte(op);
         chk("R11 modes", {rmode, wmode}, 0);
         sclk = 1'b1; hold();
         chk("R11 dout", dout, 1);
         sclk = 1'b0; hold();
         chk("R11 stored", {cfg, pn, samp}, {m_cfg(), m_n, m_samp});
      end

      // R1 start in the middle of an opcode
      start_frame();
      send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(1);
      send_byte(8'h80 | 8'd17);
      m_samp = 6'd17;
      chk("R1 mid_opcode", samp, m_samp);

      // R1 start in the middle of a response
      send_byte(8'h02);
      sclk = 1'b1; hold(); sclk = 1'b0; hold();
      sclk = 1'b1; hold(); sclk = 1'b0; hold();
      send_byte(8'h80 | 8'd42);
      m_samp = 6'd42;
      chk("R1 mid_resp_samp", samp, m_samp);
      chk("R1 mid_resp_dout", dout, 1);
      send_byte(8'h02);
      get_resp(r, rel);
      chk("R1 R4 resp_after_abort", r, {2'b00, m_samp});

      // R1 start while in write mode
      send_byte(8'h1A);
      m_n = 4'hA;
      start_frame();
      chk("R1 abort_write", wmode, 0);
      send_bit(0); send_bit(0); send_bit(0); send_bit(0);
      send_bit(0); send_bit(1); send_bit(0); send_bit(0);
      get_resp(r, rel);
      chk("R1 R6 page0_after_abort", r, {m_n, m_page[0]});

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule